// File: doc/BRIEF.md
# Fixed-Address Processor State Loader

This sequencer rebuilds a processor's architectural state from a fixed image in low memory. A single `start` pulse makes it fetch, one request at a time, the flag word, the instruction pointer, the four segment selectors, the eight general registers and the four 24-bit segment bases. Every fetch uses segment base zero. The addresses are hard-coded.

The loaded values are kept in shadow storage while the walk runs. They are published on the parallel output bus only when the last read has returned, and a single `commit` strobe marks that moment. `done` follows one clock later. A constant cycle-cost figure is also exported so that an instruction sequencer can charge the operation to its cycle budget.

Top module: `state_image_loader`

## Requirements
- R1: After reset, `mem_req`, `commit` and `done` are low, and every loaded-value output is zero.
- R2: One run issues exactly 22 reads, in this order: 0x818, 0x81A, 0x81E, 0x820, 0x822, 0x824, 0x826 to 0x834 in steps of 2, 0x836, 0x838, 0x83C, 0x83E, 0x842, 0x844, 0x848, 0x84A. `mem_byte`=1 only at 0x838, 0x83E, 0x844 and 0x84A. `mem_req` stays high with a stable address until `mem_ack`.
- R3: `flags_o` equals the word read at 0x818 ANDed with 0xFFD5, with bit 1 then set.
- R4: `ip_o` is the word at 0x81A. In `sel_o`, slot i occupies bits [16i+15:16i]. The slots are 0=ES (0x824), 1=CS (0x822), 2=SS (0x820) and 3=DS (0x81E).
- R5: In `gpr_o`, slot i occupies bits [16i+15:16i] and is loaded from the word at 0x834-2i. The slots run 0=AX, 1=CX, 2=DX, 3=BX, 4=SP, 5=BP, 6=SI, 7=DI.
- R6: In `base_o`, slot i occupies bits [24i+23:24i] and holds {byte at 0x838+6i, word at 0x836+6i}. The slots are 0=ES, 1=CS, 2=SS, 3=DS. For byte reads only `mem_rdata[7:0]` is used.
- R7: The loaded-value outputs change only in a cycle where `commit` is high. `commit` is a one-cycle pulse in the second cycle after the cycle in which the final read is acknowledged.
- R8: `done` is high for exactly one cycle, the cycle right after `commit`.
- R9: `start` is acted on only when the block is idle. A start during a run, during the commit cycle or during the done cycle issues no extra reads.
- R10: `cost_o` always equals 195.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load when idle |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | AW | Read address (segment base zero) |
| mem_byte | output | 1 | 1 = byte read, 0 = word read |
| mem_ack | input | 1 | Read data valid, request accepted |
| mem_rdata | input | 16 | Read data, little-endian word or byte in [7:0] |
| commit | output | 1 | Loaded values published this cycle |
| done | output | 1 | Load finished |
| flags_o | output | 16 | Masked flag word |
| ip_o | output | 16 | Instruction pointer |
| sel_o | output | 64 | Four segment selectors |
| gpr_o | output | 128 | Eight general registers |
| base_o | output | 96 | Four 24-bit segment bases |
| cost_o | output | 8 | Cycle cost of the operation |

## Verification
A new `start` can coincide with the sequencer's own handshake: it can arrive together with a memory acknowledge in mid-walk, or in the commit or done cycle itself. The bench raises `start` in each of those cycles while sweeping memory latency from zero to three wait cycles. It then counts the reads of the run and watches `mem_req` after `done`; any read beyond 22, or any request after `done`, counts as a miscompare. Outputs are compared every cycle against a snapshot, so a value that appears before `commit` is also caught.

// File: rtl/state_image_loader.sv
module state_image_loader #(
  parameter int AW    = 20,
  parameter int COST  = 195
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_byte,
  input  logic           mem_ack,
  input  logic [15:0]    mem_rdata,
  output logic           commit,
  output logic           done,
  output logic [15:0]    flags_o,
  output logic [15:0]    ip_o,
  output logic [63:0]    sel_o,
  output logic [127:0]   gpr_o,
  output logic [95:0]    base_o,
  output logic [7:0]     cost_o
);
  localparam int NSTEP = 22;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_XFER, S_CMT, S_DONE} st_t;
  st_t state;

  logic [4:0]  step, rel;
  logic [11:0] off;
  logic [1:0]  sidx, bidx;
  logic [2:0]  gidx;
  logic        take, last;

  logic [15:0] sh_flags, sh_ip;
  logic [15:0] sh_sel  [4];
  logic [15:0] sh_gpr  [8];
  logic [23:0] sh_base [4];
  logic [15:0] v_sel   [4];
  logic [15:0] v_gpr   [8];
  logic [23:0] v_base  [4];

  assign rel  = step - 5'd14;
  assign sidx = 2'(3'd5 - step[2:0]);
  assign gidx = 3'(4'd13 - step[3:0]);
  assign bidx = rel[2:1];
  assign take = (state == S_READ) && mem_ack;
  assign last = (step == 5'(NSTEP - 1));

  always_comb begin
    if (step < 5'd2)
      off = 12'h818 + {6'd0, step, 1'b0};
    else if (step < 5'd14)
      off = 12'h81E + {6'd0, step - 5'd2, 1'b0};
    else
      off = 12'h836 + 12'(rel[4:1]) * 12'd6 + {10'd0, rel[0], 1'b0};
  end

  assign mem_req  = (state == S_READ);
  assign mem_addr = AW'(off);
  assign mem_byte = (step >= 5'd14) && rel[0];
  assign commit   = (state == S_CMT);
  assign done     = (state == S_DONE);
  assign cost_o   = 8'(COST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      step  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin state <= S_READ; step <= '0; end
        S_READ: if (mem_ack) begin
                  if (last) state <= S_XFER;
                  else      step  <= step + 5'd1;
                end
        S_XFER: state <= S_CMT;
        S_CMT:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_flags <= '0;
      sh_ip    <= '0;
      for (int i = 0; i < 4; i++) begin sh_sel[i] <= '0; sh_base[i] <= '0; end
      for (int i = 0; i < 8; i++) sh_gpr[i] <= '0;
    end else if (take) begin
      if (step == 5'd0)       sh_flags <= (mem_rdata & 16'hFFD5) | 16'h0002;
      else if (step == 5'd1)  sh_ip <= mem_rdata;
      else if (step < 5'd6)   sh_sel[sidx] <= mem_rdata;
      else if (step < 5'd14)  sh_gpr[gidx] <= mem_rdata;
      else if (!rel[0])       sh_base[bidx][15:0]  <= mem_rdata;
      else                    sh_base[bidx][23:16] <= mem_rdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_o <= '0;
      ip_o    <= '0;
      for (int i = 0; i < 4; i++) begin v_sel[i] <= '0; v_base[i] <= '0; end
      for (int i = 0; i < 8; i++) v_gpr[i] <= '0;
    end else if (state == S_XFER) begin
      flags_o <= sh_flags;
      ip_o    <= sh_ip;
      v_sel   <= sh_sel;
      v_gpr   <= sh_gpr;
      v_base  <= sh_base;
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_seg
    assign sel_o[16*i +: 16]  = v_sel[i];
    assign base_o[24*i +: 24] = v_base[i];
  end
  for (genvar i = 0; i < 8; i++) begin : g_gpr
    assign gpr_o[16*i +: 16] = v_gpr[i];
  end
endmodule

// File: rtl/state_image_loader_chk.sv
module state_image_loader_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_byte,
  input logic          mem_ack,
  input logic          commit,
  input logic          done,
  input logic [15:0]   flags_o,
  input logic [15:0]   ip_o,
  input logic [63:0]   sel_o,
  input logic [127:0]  gpr_o,
  input logic [95:0]   base_o,
  input logic [7:0]    cost_o
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_byte));

  // R2
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || done) |-> !mem_req);

  // R3
  flag_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> flags_o[1] && !flags_o[3] && !flags_o[5]);

  // R7
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R7
  no_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> (commit || ($stable(flags_o) && $stable(ip_o) && $stable(sel_o)
                 && $stable(gpr_o) && $stable(base_o))));

  // R8
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  always_comb cost_const_chk: assert (cost_o == 8'd195);
endmodule

bind state_image_loader state_image_loader_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_byte(mem_byte), .mem_ack(mem_ack), .commit(commit), .done(done),
  .flags_o(flags_o), .ip_o(ip_o), .sel_o(sel_o), .gpr_o(gpr_o),
  .base_o(base_o), .cost_o(cost_o)
);

// File: tb/state_image_loader_tb.sv
module state_image_loader_tb;
  localparam int AW = 20;
  logic clk = 0, rst_n = 0, start = 0, mem_ack = 0;
  logic [15:0] mem_rdata = '0;
  logic mem_req, mem_byte, commit, done;
  logic [AW-1:0] mem_addr;
  logic [15:0] flags_o, ip_o;
  logic [63:0] sel_o;
  logic [127:0] gpr_o;
  logic [95:0] base_o;
  logic [7:0] cost_o;

  state_image_loader #(.AW(AW)) u_dut (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [7:0] mem [128];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL watchdog: act=%0d exp<=100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wd(input int a);
    return {mem[a - 'h800 + 1], mem[a - 'h800]};
  endfunction

  function automatic int exp_addr(input int k);
    case (k)
      0: return 'h818;  1: return 'h81A;  2: return 'h81E;  3: return 'h820;
      4: return 'h822;  5: return 'h824;  14: return 'h836; 15: return 'h838;
      16: return 'h83C; 17: return 'h83E; 18: return 'h842; 19: return 'h844;
      20: return 'h848; 21: return 'h84A;
      default: return 'h826 + 2 * (k - 6);
    endcase
  endfunction

  task automatic run(input int seed, input int lat);
    int k = 0, wc = 0, last_ack = -1, t = 0, commit_t = -1;
    bit fin = 0;
    logic [15:0] pf = flags_o, pi = ip_o;
    logic [63:0] ps = sel_o;
    logic [127:0] pg = gpr_o;
    logic [95:0] pb = base_o;
    for (int i = 0; i < 128; i++)
      mem[i] = (seed == 0) ? 8'h00 : (seed == 1) ? 8'hFF :
               8'((seed * 37 + i * 13 + (i >> 3) * seed) & 255);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!fin && t < 400) begin
      mem_ack = 0;
      start = (k == 5) || commit || done;
      if (mem_req) begin
        if (wc == lat) begin
          // R2
          chk(k < 22 && int'(mem_addr) == exp_addr(k), "R2 addr", 32'(mem_addr), 32'(exp_addr(k)));
          chk(mem_byte == (k >= 14 && k[0]), "R2 byte", 32'(mem_byte), 32'(k >= 14 && k[0]));
          mem_ack = 1;
          mem_rdata = mem_byte ? {8'hA5, mem[int'(mem_addr) - 'h800]} : wd(int'(mem_addr));
          last_ack = t; k++; wc = 0;
        end else wc++;
      end
      if (!commit && (flags_o != pf || ip_o != pi || sel_o != ps || gpr_o != pg || base_o != pb))
        chk(0, "R7 early change", 32'(t), 32'(commit_t));
      if (commit) begin
        commit_t = t;
        // R7
        chk(t == last_ack + 2 && k == 22, "R7 commit time", 32'(t), 32'(last_ack + 2));
        // R3
        chk(flags_o == ((wd('h818) & 16'hFFD5) | 16'h2), "R3 flags", 32'(flags_o), 32'((wd('h818) & 16'hFFD5) | 16'h2));
        // R4
        chk(ip_o == wd('h81A), "R4 ip", 32'(ip_o), 32'(wd('h81A)));
        for (int i = 0; i < 4; i++) begin
          chk(sel_o[16*i +: 16] == wd('h824 - 2*i), "R4 sel", 32'(sel_o[16*i +: 16]), 32'(wd('h824 - 2*i)));
          // R6
          chk(base_o[24*i +: 24] == {mem['h38 + 6*i], wd('h836 + 6*i)}, "R6 base",
              32'(base_o[24*i +: 24]), 32'({mem['h38 + 6*i], wd('h836 + 6*i)}));
        end
        for (int i = 0; i < 8; i++)
          // R5
          chk(gpr_o[16*i +: 16] == wd('h834 - 2*i), "R5 gpr", 32'(gpr_o[16*i +: 16]), 32'(wd('h834 - 2*i)));
      end
      if (done) begin
        // R8
        chk(commit_t >= 0 && t == commit_t + 1, "R8 done", 32'(t), 32'(commit_t + 1));
        fin = 1;
      end
      pf = flags_o; pi = ip_o; ps = sel_o; pg = gpr_o; pb = base_o;
      @(negedge clk); t++;
    end
    mem_ack = 0; start = 0;
    chk(fin, "R8 run end", 32'(fin), 32'd1);
    for (int j = 0; j < 4; j++) begin
      // R9
      chk(!mem_req && k == 22, "R9 no restart", 32'(k), 32'd22);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!mem_req && !commit && !done, "R1 ctrl", {29'd0, mem_req, commit, done}, 32'd0);
    chk(flags_o == 0 && ip_o == 0 && sel_o == 0 && gpr_o == 0 && base_o == 0, "R1 outs", 32'(flags_o), 32'd0);
    rst_n = 1;
    @(negedge clk);
    // R10
    chk(cost_o == 8'd195, "R10 cost", 32'(cost_o), 32'd195);
    for (int s = 0; s < 6; s++)
      for (int l = 0; l < 4; l++)
        run(s, l);
    chk(cost_o == 8'd195, "R10 cost end", 32'(cost_o), 32'd195);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule